// File: doc/BRIEF.md
# Decode-Stage Hazard Arbiter

This block sits beside the decode stage of a five-stage in-order pipeline that has separate instruction and data memories. Each cycle it examines the instruction word held in decode and compares its source registers against the instruction currently in execute. It decides whether the front of the pipe must wait for a load result, or whether the two youngest slots must be discarded because execute is redirecting the program counter.

It has three kinds of output. The hold signal freezes the program counter and the fetch/decode register. The bubble signal makes the decode/execute register take an all-zero control bundle. The flush signals turn the fetch and decode slots into no-ops. The block is purely combinational, so its decision reaches the pipeline registers in the cycle that it is needed. It decodes the raw instruction word itself, so that it can tell which register fields are actually read.

Top module: `hzd_unit`

## Requirements
- R1: When execute holds a load (`ex_load_i`=1) whose destination is non-zero and equals the rs field (bits 25:21) of an ADD, SUB, LW, SW or BEQ in decode, `hold_o` and `bubble_o` are both 1 in that cycle.
- R2: When execute holds a load whose destination is non-zero and equals the rt field (bits 20:16) of an ADD, SUB or BEQ in decode, `hold_o` and `bubble_o` are both 1.
- R3: A destination register of zero in execute never causes `hold_o` or `bubble_o`.
- R4: An instruction word that reads no register never stalls, even when its bit fields match the load destination. This covers the all-zero no-op, J (opcode 2), and opcode 0 with a function code other than 32 (add) or 34 (sub).
- R5: When execute does not hold a load (`ex_load_i`=0), `hold_o` and `bubble_o` stay 0 whatever the register fields are.
- R6: The rt field of a store (opcode 43) is its data register and never stalls, because the loaded value reaches the store through forwarding at the memory stage.
- R7: A jump in execute (`ex_jump_i`=1) drives `flush_if_o` and `flush_id_o` to 1 in the same cycle.
- R8: A branch-on-equal in execute (`ex_beq_i`=1) drives both flush outputs to 1 only when `ex_equal_i`=1. An untaken branch flushes nothing.
- R9: When a redirect and a load-use stall fall in the same cycle, the flush wins: both flush outputs are 1, and `hold_o` and `bubble_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_instr_i | input | 32 | Instruction word currently in decode |
| ex_dst_i | input | 5 | Destination register of the instruction in execute |
| ex_load_i | input | 1 | Instruction in execute reads data memory |
| ex_jump_i | input | 1 | Instruction in execute is an unconditional jump |
| ex_beq_i | input | 1 | Instruction in execute is a branch-on-equal |
| ex_equal_i | input | 1 | Equality comparison result of the branch in execute |
| hold_o | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble_o | output | 1 | Load a zero control bundle into the decode/execute register |
| flush_if_o | output | 1 | Replace the fetch-stage instruction with a no-op |
| flush_id_o | output | 1 | Replace the decode-stage instruction with a no-op |

## Verification
The load-use stall and the redirect flush can be requested in the same cycle. This happens when a load sits in execute alongside a jump or taken-branch indication, while decode holds an instruction that reads the load's destination. The bench builds that overlap with both a jump and a taken branch. It expects the flush pair high with hold and bubble low, and it repeats the same decode and load contents without the redirect to show that the stall alone would have fired.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FUNCT_W = 6;

    localparam logic [OPC_W-1:0]   OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JUMP  = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0]   OPC_STORE = 6'd43;
    localparam logic [FUNCT_W-1:0] FN_ADD    = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB    = 6'd34;

    typedef struct packed {
        logic reads_rs;
        logic reads_rt;
        logic is_store;
    } src_use_t;

    typedef struct packed {
        logic hold;
        logic bubble;
        logic flush_if;
        logic flush_id;
    } haz_ctl_t;

endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
    import hzd_pkg::*;
#(
    parameter int RADDR_W = 5
) (
    input  logic [INSTR_W-1:0] instr_i,
    output src_use_t           use_o,
    output logic [RADDR_W-1:0] rs_o,
    output logic [RADDR_W-1:0] rt_o
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - RADDR_W;
    localparam int RT_LSB  = RS_LSB - RADDR_W;

    logic [OPC_W-1:0]   opc;
    logic [FUNCT_W-1:0] fn;
    src_use_t           use_d;

    assign opc  = instr_i[INSTR_W-1:OPC_LSB];
    assign fn   = instr_i[FUNCT_W-1:0];
    assign rs_o = instr_i[RS_LSB +: RADDR_W];
    assign rt_o = instr_i[RT_LSB +: RADDR_W];

    always_comb begin
        use_d = '0;
        unique case (opc)
            OPC_RTYPE: begin
                if (fn == FN_ADD || fn == FN_SUB) begin
                    use_d.reads_rs = 1'b1;
                    use_d.reads_rt = 1'b1;
                end
            end
            OPC_BEQ: begin
                use_d.reads_rs = 1'b1;
                use_d.reads_rt = 1'b1;
            end
            OPC_LOAD: begin
                use_d.reads_rs = 1'b1;
            end
            OPC_STORE: begin
                use_d.reads_rs = 1'b1;
                use_d.is_store = 1'b1;
            end
            default: use_d = '0;
        endcase
    end

    assign use_o = use_d;

    always_comb begin
        a_r6_store_data_free: assert (!(use_d.is_store && use_d.reads_rt))
            else $error("R6: store data field marked as a stall source");
    end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse
    import hzd_pkg::*;
#(
    parameter int RADDR_W = 5
) (
    input  src_use_t           use_i,
    input  logic [RADDR_W-1:0] rs_i,
    input  logic [RADDR_W-1:0] rt_i,
    input  logic [RADDR_W-1:0] ex_dst_i,
    input  logic               ex_load_i,
    output logic               stall_o
);
    logic dst_live;
    logic hit_rs;
    logic hit_rt;

    assign dst_live = ex_load_i && (ex_dst_i != '0);
    assign hit_rs   = use_i.reads_rs && (rs_i == ex_dst_i);
    assign hit_rt   = use_i.reads_rt && (rt_i == ex_dst_i);
    assign stall_o  = dst_live && (hit_rs || hit_rt);
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect (
    input  logic ex_jump_i,
    input  logic ex_beq_i,
    input  logic ex_equal_i,
    output logic redirect_o
);
    logic beq_taken;

    assign beq_taken  = ex_beq_i && ex_equal_i;
    assign redirect_o = ex_jump_i || beq_taken;
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int RADDR_W = 5
) (
    input  logic [INSTR_W-1:0] id_instr_i,
    input  logic [RADDR_W-1:0] ex_dst_i,
    input  logic               ex_load_i,
    input  logic               ex_jump_i,
    input  logic               ex_beq_i,
    input  logic               ex_equal_i,
    output logic               hold_o,
    output logic               bubble_o,
    output logic               flush_if_o,
    output logic               flush_id_o
);
    src_use_t           id_use;
    logic [RADDR_W-1:0] id_rs;
    logic [RADDR_W-1:0] id_rt;
    logic               lu_stall;
    logic               redirect;
    haz_ctl_t           haz_d;

    hzd_decode #(.RADDR_W(RADDR_W)) i_decode (
        .instr_i (id_instr_i),
        .use_o   (id_use),
        .rs_o    (id_rs),
        .rt_o    (id_rt)
    );

    hzd_loaduse #(.RADDR_W(RADDR_W)) i_loaduse (
        .use_i     (id_use),
        .rs_i      (id_rs),
        .rt_i      (id_rt),
        .ex_dst_i  (ex_dst_i),
        .ex_load_i (ex_load_i),
        .stall_o   (lu_stall)
    );

    hzd_redirect i_redirect (
        .ex_jump_i  (ex_jump_i),
        .ex_beq_i   (ex_beq_i),
        .ex_equal_i (ex_equal_i),
        .redirect_o (redirect)
    );

    // Priority: a redirect squashes the decode slot, so its stall is void.
    always_comb begin
        haz_d          = '0;
        haz_d.flush_if = redirect;
        haz_d.flush_id = redirect;
        if (!redirect && lu_stall) begin
            haz_d.hold   = 1'b1;
            haz_d.bubble = 1'b1;
        end
    end

    assign hold_o     = haz_d.hold;
    assign bubble_o   = haz_d.bubble;
    assign flush_if_o = haz_d.flush_if;
    assign flush_id_o = haz_d.flush_id;

    always_comb begin
        a_r3_zero_dst: assert (!((ex_dst_i == '0) && lu_stall))
            else $error("R3: stall raised for register zero");
        a_r4_nop_quiet: assert (!((id_instr_i == '0) && lu_stall))
            else $error("R4: all-zero word produced a stall");
        a_r5_no_load_no_stall: assert (!(!ex_load_i && lu_stall))
            else $error("R5: stall without a load in execute");
        a_r9_flush_wins: assert (!(flush_id_o && (hold_o || bubble_o)))
            else $error("R9: stall outputs active during a flush");
        a_r8_untaken_quiet: assert (!(!ex_jump_i && !(ex_beq_i && ex_equal_i) && flush_if_o))
            else $error("R8: flush without a redirect");
    end
endmodule

// File: tb/test_hzd_unit.sv
module test_hzd_unit;
    localparam int CLK_PERIOD = 10;

    typedef enum int { K_ADD, K_SUB, K_LW, K_SW, K_BEQ, K_J, K_NOP, K_ODD } kind_t;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic [31:0] id_instr = '0;
    logic [4:0]  ex_dst = '0;
    logic        ex_load = 1'b0;
    logic        ex_jump = 1'b0;
    logic        ex_beq = 1'b0;
    logic        ex_equal = 1'b0;
    logic        hold, bubble, flush_if, flush_id;

    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_unit i_hzd_unit (
        .id_instr_i (id_instr),
        .ex_dst_i   (ex_dst),
        .ex_load_i  (ex_load),
        .ex_jump_i  (ex_jump),
        .ex_beq_i   (ex_beq),
        .ex_equal_i (ex_equal),
        .hold_o     (hold),
        .bubble_o   (bubble),
        .flush_if_o (flush_if),
        .flush_id_o (flush_id)
    );

    function automatic logic [31:0] build(kind_t k, logic [4:0] rs, logic [4:0] rt);
        case (k)
            K_ADD:   return {6'd0,  rs, rt, 5'd1, 5'd0, 6'd32};
            K_SUB:   return {6'd0,  rs, rt, 5'd1, 5'd0, 6'd34};
            K_LW:    return {6'd35, rs, rt, 16'h0004};
            K_SW:    return {6'd43, rs, rt, 16'h0004};
            K_BEQ:   return {6'd4,  rs, rt, 16'h0003};
            K_J:     return {6'd2,  rs, rt, 16'h0000};
            K_ODD:   return {6'd0,  rs, rt, 5'd3, 5'd0, 6'd7};
            default: return 32'h0;
        endcase
    endfunction

    task automatic drive(kind_t k, logic [4:0] rs, logic [4:0] rt, logic [4:0] dst,
                         logic ld, logic jmp, logic beq, logic eq, string tag);
        logic  uses_rs, uses_rt, stall, redir;
        item_t it;
        @(posedge clk);
        id_instr = build(k, rs, rt);
        ex_dst   = dst;
        ex_load  = ld;
        ex_jump  = jmp;
        ex_beq   = beq;
        ex_equal = eq;
        uses_rs = (k == K_ADD) || (k == K_SUB) || (k == K_LW) || (k == K_SW) || (k == K_BEQ);
        uses_rt = (k == K_ADD) || (k == K_SUB) || (k == K_BEQ);
        stall   = ld && (dst != 5'd0) && ((uses_rs && rs == dst) || (uses_rt && rt == dst));
        redir   = jmp || (beq && eq);
        it.exp  = {stall && !redir, stall && !redir, redir, redir};
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = sb_q.pop_front();
                act = {hold, bubble, flush_if, flush_id};
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual hold/bubble/fif/fid=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        // idle / reset state
        drive(K_NOP, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, "reset idle");
        // R1: rs hit for each reading kind
        drive(K_ADD, 5'd3, 5'd4, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R1 add rs");
        drive(K_SUB, 5'd7, 5'd1, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, "R1 sub rs");
        drive(K_LW,  5'd9, 5'd2, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, "R1 lw base");
        drive(K_SW,  5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, "R1 sw base");
        drive(K_BEQ, 5'd31, 5'd2, 5'd31, 1'b1, 1'b0, 1'b0, 1'b0, "R1 beq rs");
        // R2: rt hit
        drive(K_ADD, 5'd1, 5'd12, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0, "R2 add rt");
        drive(K_BEQ, 5'd2, 5'd17, 5'd17, 1'b1, 1'b0, 1'b0, 1'b0, "R2 beq rt");
        drive(K_LW,  5'd4, 5'd8, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0, "R2 lw rt is dest");
        // R3: register zero
        drive(K_ADD, 5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 zero dst");
        drive(K_BEQ, 5'd0, 5'd5, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 beq zero");
        // R4: non-reading words
        drive(K_NOP, 5'd0, 5'd0, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R4 nop");
        drive(K_J,   5'd6, 5'd6, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R4 jump fields");
        drive(K_ODD, 5'd6, 5'd6, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R4 odd funct");
        // R5: no load in execute
        drive(K_ADD, 5'd3, 5'd3, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R5 no load");
        drive(K_SUB, 5'd2, 5'd9, 5'd10, 1'b1, 1'b0, 1'b0, 1'b0, "R5 no match");
        // R6: store data register
        drive(K_SW,  5'd1, 5'd14, 5'd14, 1'b1, 1'b0, 1'b0, 1'b0, "R6 sw data");
        // R7 / R8: redirects
        drive(K_ADD, 5'd1, 5'd2, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R7 jump");
        drive(K_NOP, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 beq taken");
        drive(K_NOP, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 beq not taken");
        drive(K_NOP, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 equal w/o beq");
        // R9: overlap
        drive(K_ADD, 5'd11, 5'd2, 5'd11, 1'b1, 1'b0, 1'b0, 1'b0, "R9 stall alone");
        drive(K_ADD, 5'd11, 5'd2, 5'd11, 1'b1, 1'b1, 1'b0, 1'b0, "R9 jump over stall");
        drive(K_BEQ, 5'd3, 5'd11, 5'd11, 1'b1, 1'b0, 1'b1, 1'b1, "R9 beq over stall");
        drive(K_BEQ, 5'd3, 5'd11, 5'd11, 1'b1, 1'b0, 1'b1, 1'b0, "R9 untaken keeps stall");
        @(posedge clk);
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule